// File: doc/BRIEF.md
# Triggered Single-Channel Transfer Controller

This block is a one-channel data mover. Software loads two address pointers, a transfer count and a control word holding an enable bit, a 4-bit mode and a trigger source. When the chosen source fires, the channel requests a byte-wide bus. Once it holds the grant it moves data as read-then-write byte cycles, using a holding register between the read and the write.

Pointer 0 always addresses memory. Pointer 1 addresses either an 8-bit I/O area (modes 0 to 9) or the full memory space (modes A to F). The sixteen modes cover single bytes, words moved as two byte cycles, paired transfers that read and then write back, and count-terminated bursts. The remaining count, the pointers and the enable and error flags are visible on output ports. A done output pulses when the count runs out.

Top module: `xfer_ctl`

## Requirements
- R1: After reset the pointers and count are zero, the enable, error and done outputs are low, and no bus request is made.
- R2: Modes 0 and 1 move one byte from memory at pointer 0 to I/O at pointer 1, or from I/O to memory, respectively, with neither pointer changed. An I/O access drives bus_io high and puts only bits 7:0 of pointer 1 on the address, with all upper bits zero.
- R3: Modes 2 and 3 behave like modes 0 and 1, except that pointer 0 grows by one after each unit.
- R4: Modes 4 (memory to I/O) and 5 (I/O to memory) each move two bytes. The first byte uses pointer 0 and I/O address pointer 1. The second byte uses pointer 0 + 1 and I/O address pointer 1 with bit 0 set. Pointer 0 then grows by two.
- R5: Modes 6 to 9 each do two bytes. The first byte goes from I/O at pointer 1 to memory at pointer 0. The second byte goes from memory at pointer 0 + 1 to I/O. Modes 8 and 9 use the odd I/O address for that second byte; modes 6 and 7 reuse pointer 1. Modes 6 and 8 advance pointer 0 by two; modes 7 and 9 leave it unchanged.
- R6: In modes A to F, pointer 1 is a full memory address and bus_io is low. Modes A and B (pointer 0 to pointer 1, and back) move one byte with no pointer change. Modes C and D move two bytes, at offsets 0 and 1 from both pointers, and then advance both pointers by two.
- R7: Modes E (pointer 0 to pointer 1) and F (reverse) run as a burst. One trigger moves bytes until the count is zero, both pointers grow by one per byte, and the bus request stays high for the whole burst.
- R8: The trigger select, control bits 8:5, picks which event line starts a unit. A start happens only on a rising edge of the selected line; other lines are ignored. A select value of 12 or more picks software start. Software start is requested by writing the control register with bit 9 set, and it takes effect one cycle after that write.
- R9: Each unit, or each burst byte, lowers the count by one. When the count reaches zero, the enable bit clears and done pulses high for exactly one cycle. Starts are accepted only while the count is non-zero.
- R10: The controller makes no bus access before bus_gnt. Every byte is one read cycle followed by one write cycle of the byte that was read. The request stays high from the start of a unit until it ends, so a single-byte unit with immediate grant holds the request for 3 cycles.
- R11: A trigger that arrives while a unit is in progress is remembered and serviced after that unit ends. Triggers are ignored while the enable bit is low.
- R12: In modes 4 to 9, C and D, a start with bit 0 of pointer 1 set does not touch the bus. Instead it sets the error output and clears the enable bit.
- R13: Register writes are ignored while a unit is in progress. Register select 0 is pointer 0, 1 is pointer 1, 2 is the count and 3 is the control word, whose bit 0 is the enable. Any accepted control write clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 pointer 0, 1 pointer 1, 2 count, 3 control |
| cfg_wdata | input | W | Register write data |
| evt | input | NTRIG | Peripheral event lines |
| bus_req | output | 1 | Bus request, held for a whole unit or burst |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | W | Access address |
| bus_io | output | 1 | Access targets the I/O area |
| bus_we | output | 1 | High for a write cycle, low for a read cycle |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| ptr0_o | output | W | Pointer 0 |
| ptr1_o | output | W | Pointer 1 |
| count_o | output | W | Remaining transfer count |
| en_o | output | 1 | Channel enable |
| err_o | output | 1 | Odd-pointer error flag |
| done_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The assertions assume that the bus grant, once given, stays high for as long as the request is held. This means every read cycle is granted and is followed by its write. They also assume that read data is valid in the same cycle as the read address. The bench's grant model raises the grant a set number of cycles after the request and drops it only when the request falls. Its memory model returns data from the current address without delay. Event lines and register writes are driven between clock edges.

// File: rtl/xfer_ctl.sv
module xfer_ctl #(
  parameter int W     = 16,
  parameter int NTRIG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [W-1:0]     cfg_wdata,
  input  logic [NTRIG-1:0] evt,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [W-1:0]     bus_addr,
  output logic             bus_io,
  output logic             bus_we,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic [W-1:0]     ptr0_o,
  output logic [W-1:0]     ptr1_o,
  output logic [W-1:0]     count_o,
  output logic             en_o,
  output logic             err_o,
  output logic             done_o
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} st_t;

  st_t            state;
  logic [W-1:0]   p0, p1, cnt;
  logic [3:0]     mode, tsel;
  logic           en, err, done, pend, sw_q, step;
  logic [7:0]     hold;
  logic [NTRIG-1:0] evt_q;
  logic [W-1:0]   inc0, inc1;

  wire two   = (mode >= 4'd4 && mode <= 4'd9) || mode == 4'hC || mode == 4'hD;
  wire burst = mode[3:1] == 3'b111;
  wire memsp = mode >= 4'hA;
  wire pair  = mode >= 4'd6 && mode <= 4'd9;
  wire oddio = mode == 4'd4 || mode == 4'd5 || mode == 4'd8 || mode == 4'd9;
  wire to_p1 = pair ? step : ~mode[0];

  wire [W-1:0] a0 = p0 + W'(step);
  wire [W-1:0] a1 = memsp ? p1 + W'(step)
                          : {{(W-8){1'b0}}, p1[7:1], p1[0] | (step & oddio)};
  wire [W-1:0] src = to_p1 ? a0 : a1;
  wire [W-1:0] dst = to_p1 ? a1 : a0;

  wire [15:0] rise  = 16'(evt & ~evt_q);
  wire        swsel = !(32'(tsel) < NTRIG);
  wire        hit   = en && cnt != '0 && ((!swsel && rise[tsel]) || (swsel && sw_q));
  wire        idle  = state == S_IDLE;
  wire        cfg_ok = cfg_we && idle;

  always_comb begin
    inc0 = '0;
    inc1 = '0;
    case (mode)
      4'd2, 4'd3:               inc0 = W'(1);
      4'd4, 4'd5, 4'd6, 4'd8:   inc0 = W'(2);
      4'hC, 4'hD: begin         inc0 = W'(2); inc1 = W'(2); end
      4'hE, 4'hF: begin         inc0 = W'(1); inc1 = W'(1); end
      default: ;
    endcase
  end

  assign bus_req   = !idle;
  assign bus_we    = state == S_WR;
  assign bus_addr  = bus_we ? dst : src;
  assign bus_io    = !memsp && (bus_we ? to_p1 : !to_p1);
  assign bus_wdata = hold;
  assign ptr0_o    = p0;
  assign ptr1_o    = p1;
  assign count_o   = cnt;
  assign en_o      = en;
  assign err_o     = err;
  assign done_o    = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      p0 <= '0; p1 <= '0; cnt <= '0;
      mode <= '0; tsel <= '0;
      en <= 1'b0; err <= 1'b0; done <= 1'b0;
      pend <= 1'b0; sw_q <= 1'b0; step <= 1'b0;
      hold <= '0; evt_q <= '0;
    end else begin
      done  <= 1'b0;
      evt_q <= evt;
      sw_q  <= cfg_ok && cfg_sel == 2'd3 && cfg_wdata[9];
      if (cfg_ok) begin
        case (cfg_sel)
          2'd0: p0  <= cfg_wdata;
          2'd1: p1  <= cfg_wdata;
          2'd2: cnt <= cfg_wdata;
          default: begin
            en   <= cfg_wdata[0];
            mode <= cfg_wdata[4:1];
            tsel <= cfg_wdata[8:5];
            err  <= 1'b0;
            pend <= 1'b0;
          end
        endcase
      end else begin
        if (hit && !idle) pend <= 1'b1;
        case (state)
          S_IDLE: if (hit || (pend && en && cnt != '0)) begin
            pend <= 1'b0;
            if (two && p1[0]) begin
              err <= 1'b1;
              en  <= 1'b0;
            end else begin
              state <= S_REQ;
              step  <= 1'b0;
            end
          end
          S_REQ: if (bus_gnt) state <= S_RD;
          S_RD: begin
            hold  <= bus_rdata;
            state <= S_WR;
          end
          default: begin
            if (two && !step) begin
              step  <= 1'b1;
              state <= S_RD;
            end else begin
              step <= 1'b0;
              p0   <= p0 + inc0;
              p1   <= p1 + inc1;
              cnt  <= cnt - W'(1);
              if (cnt == W'(1)) begin
                en    <= 1'b0;
                done  <= 1'b1;
                pend  <= 1'b0;
                state <= S_IDLE;
              end else if (burst) begin
                state <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
        endcase
      end
    end
  end

  p_io_low8_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_io) |-> bus_addr[W-1:8] == '0);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req) && count_o != $past(count_o)) |-> count_o == $past(count_o) - W'(1));

  p_done_clears_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !en_o);

  p_write_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $past(bus_req && !bus_we && bus_gnt));

  p_req_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> en_o);

  p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !bus_req);

endmodule

// File: tb/tb_xfer_ctl.sv
`timescale 1ns/1ps
module tb_xfer_ctl;
  localparam int W = 16;
  localparam int NTRIG = 12;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [W-1:0] cfg_wdata = 0;
  logic [NTRIG-1:0] evt = 0;
  logic bus_req, bus_gnt = 0, bus_io, bus_we, en_o, err_o, done_o;
  logic [W-1:0] bus_addr, ptr0_o, ptr1_o, count_o;
  logic [7:0] bus_wdata, bus_rdata;

  logic [7:0] mem [0:1023];
  logic [7:0] iom [0:255];

  typedef struct packed { logic io; logic [15:0] a; logic [7:0] d; } item_t;
  item_t expq[$];

  int checks = 0, fails = 0, gdly = 0, gcnt = 0;
  int reqfalls = 0, dones = 0, reqcyc = 0, lastcyc = 0, cycles = 0;
  logic reqprev = 0;
  string cur = "R1";

  xfer_ctl #(.W(W), .NTRIG(NTRIG)) dut (.*);

  always #10 clk = ~clk;

  assign bus_rdata = bus_io ? iom[bus_addr[7:0]] : mem[bus_addr[9:0]];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (bus_req) begin
      if (gcnt >= gdly) bus_gnt <= 1'b1; else gcnt++;
      reqcyc++;
    end else begin
      bus_gnt <= 1'b0;
      gcnt = 0;
      if (reqprev) begin reqfalls++; lastcyc = reqcyc; reqcyc = 0; end
    end
    reqprev = bus_req;
    if (done_o) dones++;
    if (bus_req && bus_gnt && bus_we) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL %s actual=%b/%h/%h expected=no write", cur, bus_io, bus_addr, bus_wdata);
      end else begin
        item_t e;
        e = expq.pop_front();
        if (e.io !== bus_io || e.a !== bus_addr || e.d !== bus_wdata) begin
          fails++;
          $display("FAIL %s actual=%b/%h/%h expected=%b/%h/%h", cur,
                   bus_io, bus_addr, bus_wdata, e.io, e.a, e.d);
        end
      end
      if (bus_io) iom[bus_addr[7:0]] = bus_wdata;
      else mem[bus_addr[9:0]] = bus_wdata;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cfg(logic [1:0] s, logic [W-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [W-1:0] ctl(int md, int sl);
    return W'((sl << 5) | (md << 1) | 1);
  endfunction

  task automatic setup(logic [W-1:0] a0, logic [W-1:0] a1, logic [W-1:0] n, int md, int sl);
    cfg(0, a0); cfg(1, a1); cfg(2, n); cfg(3, ctl(md, sl));
  endtask

  task automatic push(logic io, logic [15:0] a, logic [7:0] d);
    item_t e;
    e.io = io; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  task automatic pulse(int n);
    @(negedge clk); evt[n] = 1'b1;
    @(negedge clk); evt[n] = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (bus_req) q = 0; else q++;
    end
    chk({cur, " queue"}, expq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 256; i++) iom[i] = 8'(i ^ 8'hA5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 en", en_o, 0); chk("R1 req", bus_req, 0);
    chk("R1 cnt", count_o, 0); chk("R1 p0", ptr0_o, 0); chk("R1 err", err_o, 0);
    chk("R1 done", done_o, 0);

    cur = "R2";
    setup(16'h0010, 16'h1234, 3, 0, 2);
    push(1, 16'h0034, mem[16'h10]);
    pulse(2); wait_idle();
    chk("R2 p0", ptr0_o, 16'h0010); chk("R2 p1", ptr1_o, 16'h1234);
    chk("R9 cnt", count_o, 2); chk("R9 en", en_o, 1);
    chk("R10 req cycles", lastcyc, 3);
    setup(16'h0015, 16'h0255, 3, 1, 2);
    push(0, 16'h0015, iom[8'h55]);
    pulse(2); wait_idle();
    chk("R2 p0 m1", ptr0_o, 16'h0015);

    cur = "R3";
    setup(16'h0020, 16'h0040, 5, 2, 2);
    push(1, 16'h0040, mem[16'h20]); pulse(2); wait_idle();
    push(1, 16'h0040, mem[16'h21]); pulse(2); wait_idle();
    chk("R3 p0", ptr0_o, 16'h0022); chk("R3 cnt", count_o, 3);
    setup(16'h0030, 16'h0041, 5, 3, 2);
    push(0, 16'h0030, iom[8'h41]); pulse(2); wait_idle();
    chk("R3 p0 m3", ptr0_o, 16'h0031);

    cur = "R4";
    setup(16'h0050, 16'h0360, 5, 4, 2);
    push(1, 16'h0060, mem[16'h50]); push(1, 16'h0061, mem[16'h51]);
    pulse(2); wait_idle();
    chk("R4 p0", ptr0_o, 16'h0052); chk("R4 p1", ptr1_o, 16'h0360); chk("R4 cnt", count_o, 4);
    setup(16'h0058, 16'h0062, 5, 5, 2);
    push(0, 16'h0058, iom[8'h62]); push(0, 16'h0059, iom[8'h63]);
    pulse(2); wait_idle();
    chk("R4 p0 m5", ptr0_o, 16'h005A);

    cur = "R5";
    setup(16'h0070, 16'h0080, 5, 8, 2);
    push(0, 16'h0070, iom[8'h80]); push(1, 16'h0081, mem[16'h71]);
    pulse(2); wait_idle();
    chk("R5 p0 m8", ptr0_o, 16'h0072);
    setup(16'h0078, 16'h0090, 5, 7, 2);
    push(0, 16'h0078, iom[8'h90]); push(1, 16'h0090, mem[16'h79]);
    pulse(2); wait_idle();
    chk("R5 p0 m7", ptr0_o, 16'h0078);

    cur = "R6";
    setup(16'h0100, 16'h0300, 5, 11, 2);
    push(0, 16'h0100, mem[16'h300]); pulse(2); wait_idle();
    chk("R6 p0 mB", ptr0_o, 16'h0100); chk("R6 p1 mB", ptr1_o, 16'h0300);
    setup(16'h0110, 16'h0310, 5, 12, 2);
    push(0, 16'h0310, mem[16'h110]); push(0, 16'h0311, mem[16'h111]);
    pulse(2); wait_idle();
    chk("R6 p0 mC", ptr0_o, 16'h0112); chk("R6 p1 mC", ptr1_o, 16'h0312);

    cur = "R7";
    setup(16'h0140, 16'h0340, 4, 14, 2);
    for (int i = 0; i < 4; i++) push(0, 16'(16'h0340 + i), mem[16'h140 + i]);
    reqfalls = 0; dones = 0;
    pulse(2); wait_idle();
    chk("R7 one request", reqfalls, 1); chk("R7 p0", ptr0_o, 16'h0144);
    chk("R7 p1", ptr1_o, 16'h0344); chk("R9 cnt zero", count_o, 0);
    chk("R9 en cleared", en_o, 0); chk("R9 one done", dones, 1);
    cur = "R11";
    pulse(2); wait_idle();
    chk("R11 disabled ignored", reqfalls, 1);

    cur = "R8";
    setup(16'h0180, 16'h0010, 5, 0, 2);
    pulse(5); wait_idle();
    chk("R8 other line", count_o, 5);
    push(1, 16'h0010, mem[16'h180]);
    @(negedge clk); evt[2] = 1'b1;
    repeat (8) @(negedge clk);
    evt[2] = 1'b0;
    wait_idle();
    chk("R8 edge only", count_o, 4);
    setup(16'h0181, 16'h0011, 5, 0, 12);
    pulse(2); wait_idle();
    chk("R8 hw ignored in sw", count_o, 5);
    push(1, 16'h0011, mem[16'h181]);
    cfg(3, ctl(0, 12) | W'(16'h0200));
    wait_idle();
    chk("R8 sw start", count_o, 4);

    cur = "R11";
    gdly = 6;
    setup(16'h01A0, 16'h0020, 5, 2, 3);
    push(1, 16'h0020, mem[16'h1A0]); push(1, 16'h0020, mem[16'h1A1]);
    pulse(3); repeat (2) @(negedge clk); pulse(3);
    wait_idle();
    chk("R11 pending cnt", count_o, 3); chk("R11 pending p0", ptr0_o, 16'h01A2);

    cur = "R13";
    setup(16'h01D0, 16'h0024, 5, 0, 2);
    push(1, 16'h0024, mem[16'h1D0]);
    pulse(2); repeat (2) @(negedge clk);
    cfg(0, 16'h03FF);
    wait_idle();
    chk("R13 write ignored", ptr0_o, 16'h01D0); chk("R13 cnt", count_o, 4);
    gdly = 0;

    cur = "R12";
    setup(16'h01C0, 16'h0033, 5, 4, 2);
    reqfalls = 0;
    pulse(2); wait_idle();
    chk("R12 err", err_o, 1); chk("R12 en", en_o, 0);
    chk("R12 cnt", count_o, 5); chk("R12 no bus", reqfalls, 0);
    cfg(3, ctl(0, 2));
    chk("R13 err cleared", err_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule